// File: doc/BRIEF.md
# Eight-Character Display Line Buffer

This block holds one line of eight characters for a small text display and exposes it as an 8-byte window to a bus master. The master can read or write 1, 2, 4 or 8 bytes in one access, starting at any byte offset in the window. Byte k of an access lands on buffer entry (offset + k) mod 8. An access that starts near the top of the window therefore continues at entry 0.

After each accepted write the block raises a one-cycle refresh strobe. A downstream display driver then redraws the whole line from column 0, using the parallel `line_out` view. When the display link reports a connection for the first time, the block raises a one-cycle blank strobe, which asks the driver to print a line of spaces, and it sets a sticky initialised flag. The buffer itself resets to spaces.

Top module: `charbuf_top`

## Requirements
- R1: During and after reset every buffer entry is 0x20 (space), `refresh_pulse`, `blank_pulse` and `init_done` are 0, and `bus_rdata` is 0.
- R2: Byte k of an access maps to buffer entry (`bus_offset` + k) mod 8. A 4-byte write at offset 6 fills entries 6, 7, 0 and 1.
- R3: `bus_size` gives the byte count as a plain binary number, and the legal values are 1, 2, 4 and 8. Byte k travels on data bits [8k+7:8k], and entry i appears on `line_out` bits [8i+7:8i].
- R4: A read returns the requested bytes in the low lanes and zero in every higher lane. `bus_rdata` is combinational and is zero while `bus_rd` is low.
- R5: An access with an illegal `bus_size` (0, 3, 5, 6, 7, 9 to 15) changes no entry and raises no refresh strobe on write, and it reads as zero.
- R6: `refresh_pulse` is high for exactly the one cycle after a clock edge that commits a legal write. In that cycle `line_out` already holds the new contents. It is never high otherwise.
- R7: The first `link_evt` pulse sampled after reset makes `blank_pulse` high for the following cycle, and `init_done` goes high in that same cycle and stays high.
- R8: Once `init_done` is set, further `link_evt` pulses raise no blank strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request, committed at the clock edge |
| bus_rd | input | 1 | Read request, data returned in the same cycle |
| bus_offset | input | 3 | Start byte offset in the window |
| bus_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| bus_wdata | input | 64 | Write data, byte k on bits [8k+7:8k] |
| bus_rdata | output | 64 | Read data, unused lanes zero |
| link_evt | input | 1 | Display connect event pulse |
| line_out | output | 64 | Whole line, entry i on bits [8i+7:8i] |
| refresh_pulse | output | 1 | Redraw the whole line strobe |
| blank_pulse | output | 1 | Print a blank line strobe |
| init_done | output | 1 | Sticky initialised flag |

## Verification
The checker watches the strobe timing on every cycle:
- a refresh follows every legal write and nothing else;
- the line only moves after legal writes;
- a blank strobe coincides with the flag and never repeats once the flag is up;
- idle and single-byte reads keep their upper lanes at zero.

The wrapped placement of bytes can only be shown by the bench's scenarios. The bench compares the buffer's contents against a byte model after directed wrap cases and random mixed accesses. The same holds for lane order and for the exact bytes returned by multi-byte reads.

// File: rtl/charbuf_pkg.sv
// Shared constants and helpers for the display line buffer.
// Assumes the window size is a power of two so index arithmetic wraps by truncation.
package charbuf_pkg;

    localparam logic [7:0] BLANK_CHAR = 8'h20;

    // True when sz is a nonzero power of two no larger than maxb.
    function automatic logic size_legal(input logic [15:0] sz, input int unsigned maxb);
        return (sz != 16'd0) && ((sz & (sz - 16'd1)) == 16'd0) && (32'(sz) <= maxb);
    endfunction

endpackage

// File: rtl/charbuf_lane_map.sv
// Steers write bytes onto buffer entries with modulo wraparound.
// For each entry i it finds the access byte k = (i - offset) mod N and enables the
// entry when k is below the access byte count. Assumes N is a power of two.
module charbuf_lane_map #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int SZ_W  = IDX_W + 1
) (
    input  logic [IDX_W-1:0]         offset,
    input  logic [SZ_W-1:0]          count,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES-1:0]        wen,
    output logic [NBYTES*BYTE_W-1:0] wbytes
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_entry
        logic [IDX_W-1:0] k;
        // Locate the access byte that targets entry i.
        always_comb begin
            k = IDX_W'(i) - offset;
            wen[i] = ({1'b0, k} < count);
            wbytes[i*BYTE_W +: BYTE_W] = wdata[k*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/charbuf_read_mux.sv
// Gathers read bytes from the buffer starting at an offset, wrapping modulo N.
// Lanes at or above the byte count, and all lanes when no read is requested, are zero.
module charbuf_read_mux #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int SZ_W  = IDX_W + 1
) (
    input  logic                     rd,
    input  logic [IDX_W-1:0]         offset,
    input  logic [SZ_W-1:0]          count,
    input  logic [NBYTES*BYTE_W-1:0] line,
    output logic [NBYTES*BYTE_W-1:0] rdata
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        logic [IDX_W-1:0] idx;
        // Select the entry for lane k or force zero.
        always_comb begin
            idx = offset + IDX_W'(k);
            if (rd && (SZ_W'(k) < count))
                rdata[k*BYTE_W +: BYTE_W] = line[idx*BYTE_W +: BYTE_W];
            else
                rdata[k*BYTE_W +: BYTE_W] = '0;
        end
    end

endmodule

// File: rtl/charbuf_link_init.sv
// One-shot blank-line request on the first display connect event after reset.
// Assumes link_evt is a single-cycle event pulse synchronous to clk.
module charbuf_link_init (
    input  logic clk,
    input  logic rst_n,
    input  logic link_evt,
    output logic blank_pulse,
    output logic init_done
);

    // Raise the blank strobe once and latch the initialised flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_pulse <= 1'b0;
            init_done   <= 1'b0;
        end else begin
            blank_pulse <= link_evt && !init_done;
            if (link_evt)
                init_done <= 1'b1;
        end
    end

endmodule

// File: rtl/charbuf_top.sv
// Eight-character display line buffer with a byte-addressed bus port.
// Legal writes update wrapped entries and fire a refresh strobe in the next cycle.
// Reads are combinational. Assumes NBYTES is a power of two.
module charbuf_top #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int SZ_W  = IDX_W + 1,
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] bus_offset,
    input  logic [SZ_W-1:0]  bus_size,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             link_evt,
    output logic [DW-1:0]    line_out,
    output logic             refresh_pulse,
    output logic             blank_pulse,
    output logic             init_done
);
    import charbuf_pkg::*;

    logic            size_ok;
    logic [SZ_W-1:0] count;
    logic [NBYTES-1:0] wen;
    logic [DW-1:0]   wbytes;
    logic [DW-1:0]   line_q;

    // Reduce illegal sizes to a zero byte count.
    always_comb begin
        size_ok = size_legal(16'(bus_size), NBYTES);
        count   = size_ok ? bus_size : '0;
    end

    charbuf_lane_map #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_map (
        .offset (bus_offset),
        .count  (count),
        .wdata  (bus_wdata),
        .wen    (wen),
        .wbytes (wbytes)
    );

    for (genvar i = 0; i < NBYTES; i++) begin : g_store
        // Hold entry i, reset to a space, load on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                line_q[i*BYTE_W +: BYTE_W] <= BYTE_W'(BLANK_CHAR);
            else if (bus_wr && wen[i])
                line_q[i*BYTE_W +: BYTE_W] <= wbytes[i*BYTE_W +: BYTE_W];
        end
    end

    // Fire the redraw strobe after every legal write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            refresh_pulse <= 1'b0;
        else
            refresh_pulse <= bus_wr && size_ok;
    end

    charbuf_read_mux #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rd (
        .rd     (bus_rd),
        .offset (bus_offset),
        .count  (count),
        .line   (line_q),
        .rdata  (bus_rdata)
    );

    charbuf_link_init u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_evt    (link_evt),
        .blank_pulse (blank_pulse),
        .init_done   (init_done)
    );

    assign line_out = line_q;

endmodule

// File: rtl/charbuf_checker.sv
// Cycle-level properties of the line buffer, attached to charbuf_top by bind.
// Assumes default widths: 3-bit offset, 4-bit size, 64-bit data.
module charbuf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [3:0]  bus_size,
    input logic [63:0] bus_rdata,
    input logic        link_evt,
    input logic [63:0] line_out,
    input logic        refresh_pulse,
    input logic        blank_pulse,
    input logic        init_done
);

    logic legal_wr;
    // Legal write request seen at the port.
    always_comb legal_wr = bus_wr && (bus_size == 4'd1 || bus_size == 4'd2 ||
                                      bus_size == 4'd4 || bus_size == 4'd8);

    AST_REFRESH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        legal_wr |=> refresh_pulse);                                  // R6
    AST_REFRESH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> $past(legal_wr));                           // R6
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_wr |=> $stable(line_out));                             // R5
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 64'd0));                            // R4
    AST_BYTE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size == 4'd1) |-> (bus_rdata[63:8] == 56'd0)); // R4
    AST_BLANK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        blank_pulse |-> (init_done && $past(link_evt)));              // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);                                     // R7
    AST_NO_SECOND_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> !blank_pulse);                           // R8

endmodule

bind charbuf_top charbuf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_size      (bus_size),
    .bus_rdata     (bus_rdata),
    .link_evt      (link_evt),
    .line_out      (line_out),
    .refresh_pulse (refresh_pulse),
    .blank_pulse   (blank_pulse),
    .init_done     (init_done)
);

// File: tb/charbuf_top_test.sv
// Self-checking bench: directed wrap and handshake cases plus seeded random traffic.
module charbuf_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_offset = '0;
    logic [3:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        link_evt = 1'b0;
    logic [63:0] line_out;
    logic        refresh_pulse;
    logic        blank_pulse;
    logic        init_done;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;

    charbuf_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_offset(bus_offset), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .link_evt(link_evt), .line_out(line_out),
        .refresh_pulse(refresh_pulse), .blank_pulse(blank_pulse), .init_done(init_done)
    );

    function automatic bit legal(input logic [3:0] sz);
        return sz == 4'd1 || sz == 4'd2 || sz == 4'd4 || sz == 4'd8;
    endfunction

    function automatic logic [63:0] model_line();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic logic [63:0] exp_read(input logic [2:0] off, input logic [3:0] sz);
        logic [63:0] v = '0;
        if (legal(sz))
            for (int k = 0; k < int'(sz); k++) v[k*8 +: 8] = model[3'(off + 3'(k))];
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Legal or illegal write; checks strobe and line in the following cycle.
    task automatic do_write(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_offset = off; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        if (legal(sz))
            for (int k = 0; k < int'(sz); k++) model[3'(off + 3'(k))] = d[k*8 +: 8];
        @(negedge clk);
        bus_wr = 1'b0;
        check(legal(sz) ? "R6 refresh" : "R5 no refresh", 64'(refresh_pulse), 64'(legal(sz)));
        check("R2 line contents", line_out, model_line());
        @(negedge clk);
        check("R6 refresh one cycle", 64'(refresh_pulse), 64'd0);
    endtask

    task automatic do_read(input logic [2:0] off, input logic [3:0] sz, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_offset = off; bus_size = sz;
        #1;
        check(req, bus_rdata, exp_read(off, sz));
        bus_rd = 1'b0;
        #1;
        check("R4 idle read zero", bus_rdata, 64'd0);
    endtask

    task automatic pulse_link(input logic exp_blank);
        @(negedge clk);
        link_evt = 1'b1;
        @(negedge clk);
        link_evt = 1'b0;
        check(exp_blank ? "R7 blank pulse" : "R8 no repeat blank", 64'(blank_pulse), 64'(exp_blank));
        check("R7 init flag", 64'(init_done), 64'd1);
        @(negedge clk);
        check("R7 blank one cycle", 64'(blank_pulse), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F3C5A77));
        for (int i = 0; i < 8; i++) model[i] = 8'h20;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset line", line_out, {8{8'h20}});
        check("R1 reset strobes", {61'd0, refresh_pulse, blank_pulse, init_done}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset strobes", {61'd0, refresh_pulse, blank_pulse, init_done}, 64'd0);
        do_read(3'd0, 4'd8, "R1 reset read spaces");

        // R2 wrap: 4-byte write at offset 6, then full read from 0
        do_write(3'd6, 4'd4, 64'h0000_0000_4443_4241);
        do_read(3'd0, 4'd8, "R2 wrap full read");
        check("R2 entry 0 got third byte", {56'd0, line_out[7:0]}, 64'h43);
        // R3 each size with lane order
        do_write(3'd3, 4'd1, 64'h5A);
        do_write(3'd7, 4'd2, 64'h3231);
        do_write(3'd0, 4'd8, 64'h4847_4645_4443_4241);
        check("R3 lane order", line_out, 64'h4847_4645_4443_4241);
        do_read(3'd5, 4'd4, "R3 4-byte wrapped read");
        do_read(3'd7, 4'd2, "R4 2-byte read upper zero");
        // R5 illegal sizes
        do_write(3'd2, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(3'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(3'd0, 4'd6, "R5 illegal read zero");
        // R7/R8 link handshake
        check("R7 flag clear before link", 64'(init_done), 64'd0);
        pulse_link(1'b1);
        pulse_link(1'b0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] off = 3'($urandom_range(0, 7));
            logic [3:0] sz;
            logic [63:0] d = {$urandom, $urandom};
            case ($urandom_range(0, 4))
                0: sz = 4'd1;
                1: sz = 4'd2;
                2: sz = 4'd4;
                3: sz = 4'd8;
                default: sz = 4'($urandom_range(0, 15));
            endcase
            if ($urandom_range(0, 1) == 0) do_write(off, sz, d);
            else do_read(off, sz, "R2 R3 R4 random read");
        end
        do_read(3'd0, 4'd8, "R2 final line");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule